// File: doc/BRIEF.md
# Fault Injection Schedule Sequencer

This block plays back a precomputed list of fault events against a design under test that runs on a prototype. Each event arrives as a package on a valid/ready input. A package carries a relative delay and one 2-bit fault code for every monitored storage element. The delay is counted in design-clock cycles from the previous event, or from the start pulse for the first package. When the delay has elapsed, the block raises per-element control lines for exactly one cycle. These lines tell the fault-injectable storage cells to flip their bit, or to force it low or high.

Cycles are counted only on clock edges where the design-clock enable is high. Injection therefore stays aligned to the design under test when its clock is gated. Only one package is in flight at a time. Once the package flagged as last has been applied, the block reports done and waits for a new start pulse.

Top module: `fault_sched_seq`

## Requirements
- R1: While reset is asserted and after reset, all fault lines, `pkgReady`, `running` and `done` are 0 until a start pulse.
- R2: A start pulse sampled while idle or done makes `pkgReady` and `running` 1 from the next cycle. That edge is the reference edge for the first package.
- R3: A package with delay D fires on the (D+1)-th edge with `duClkEn`=1 after the reference edge. The reference edge is the start edge or the previous firing edge. The fault lines show the package's codes during the one clock cycle that follows the firing edge.
- R4: Edges where `duClkEn` is 0 are not counted and never fire a package.
- R5: The code of element i sits in `pkgCodes[2i+1:2i]`. Code 0 means no fault. Code 1 sets `faultFlip[i]`. Code 2 sets `faultForce[i]` with `faultForceVal[i]`=0. Code 3 sets `faultForce[i]` with `faultForceVal[i]`=1.
- R6: After a package is accepted without firing, `pkgReady` stays 0 until that package fires. `pkgReady` returns to 1 on the cycle after the firing edge, unless the fired package was the last one.
- R7: A delay of 0 fires on the first enabled edge after the reference edge. This includes the edge that accepts the package, so packages can fire on back-to-back cycles.
- R8: After the firing edge of a package presented with `pkgLast`=1, `done` is 1, and `pkgReady` and `running` are 0, until the next start pulse. A start pulse while running has no effect.
- R9: If the delay has already elapsed when a package is accepted, the package fires on its accepting edge if `duClkEn` is 1, otherwise on the next enabled edge. This holds even after waits longer than the counter range.
- R10: In every cycle that does not follow a firing edge, all fault lines are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast prototype clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Begins a new schedule when idle or done |
| duClkEn | input | 1 | Design-clock enable; marks counted edges |
| pkgValid | input | 1 | Package on the input is valid |
| pkgReady | output | 1 | Block accepts a package this cycle |
| pkgLast | input | 1 | Package is the final one of the schedule |
| pkgOffset | input | OFFSET_W | Relative delay in enabled cycles |
| pkgCodes | input | 2*NUM_ELEM | Per-element fault codes |
| faultFlip | output | NUM_ELEM | One-cycle bit-flip command per element |
| faultForce | output | NUM_ELEM | One-cycle force command per element |
| faultForceVal | output | NUM_ELEM | Value forced where faultForce is 1 |
| running | output | 1 | Schedule in progress |
| done | output | 1 | Last package applied |

## Verification
The bench builds the block with NUM_ELEM=5 and OFFSET_W=4. The odd element count checks that code slices are placed correctly beyond a power-of-two boundary. With a 4-bit delay, the largest delay of 15 is reachable in short runs. A late package held back for more than 15 enabled cycles drives the elapsed counter into saturation, which exercises the late-firing path. Random enable duty and input gaps then mix gated counting with both the immediate and the held firing paths.

// File: rtl/fss_pkg.sv
package fss_pkg;

  localparam int CODE_W = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_HOLD  = 2'd2,
    ST_DONE  = 2'd3
  } seqState_t;

  typedef enum logic [CODE_W-1:0] {
    FC_NONE = 2'd0,
    FC_FLIP = 2'd1,
    FC_LOW  = 2'd2,
    FC_HIGH = 2'd3
  } faultCode_t;

  typedef struct packed {
    logic clearCnt;   // restart elapsed count at this edge
    logic loadPkg;    // capture the presented package
    logic fireIn;     // apply the presented package now
    logic fireHeld;   // apply the captured package now
  } ctrlStrobe_t;

endpackage

// File: rtl/fss_ctrl.sv
module fss_ctrl
  import fss_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startPulse,
  input  logic        duClkEn,
  input  logic        pkgValid,
  input  logic        pkgLast,
  input  logic        dueIn,
  input  logic        dueHeld,
  output logic        pkgReady,
  output logic        running,
  output logic        done,
  output ctrlStrobe_t strb
);

  seqState_t state, stateNxt;
  logic      lastHeld;

  always_comb begin
    strb     = '0;
    stateNxt = state;
    unique case (state)
      ST_IDLE, ST_DONE: begin
        if (startPulse) begin
          strb.clearCnt = 1'b1;
          stateNxt      = ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (pkgValid) begin
          if (duClkEn && dueIn) begin
            strb.fireIn   = 1'b1;
            strb.clearCnt = 1'b1;
            stateNxt      = pkgLast ? ST_DONE : ST_FETCH;
          end else begin
            strb.loadPkg = 1'b1;
            stateNxt     = ST_HOLD;
          end
        end
      end
      ST_HOLD: begin
        if (duClkEn && dueHeld) begin
          strb.fireHeld = 1'b1;
          strb.clearCnt = 1'b1;
          stateNxt      = lastHeld ? ST_DONE : ST_FETCH;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      lastHeld <= 1'b0;
    end else begin
      state <= stateNxt;
      if (strb.loadPkg) lastHeld <= pkgLast;
    end
  end

  assign pkgReady = (state == ST_FETCH);
  assign running  = (state == ST_FETCH) || (state == ST_HOLD);
  assign done     = (state == ST_DONE);

  // R8: completion and acceptance never overlap
  assert_ready_excl_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    pkgReady |-> !done);

  // R6: a package taken without firing closes the input
  assert_hold_blocks_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pkgValid && pkgReady && !strb.fireIn) |=> !pkgReady);

  // R8: done only rises right after an injection edge
  assert_done_after_fire_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(strb.fireIn || strb.fireHeld));

endmodule

// File: rtl/fss_datapath.sv
module fss_datapath
  import fss_pkg::*;
#(
  parameter int NUM_ELEM = 16,
  parameter int OFFSET_W = 24
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       duClkEn,
  input  ctrlStrobe_t                strb,
  input  logic [OFFSET_W-1:0]        pkgOffset,
  input  logic [CODE_W*NUM_ELEM-1:0] pkgCodes,
  output logic                       dueIn,
  output logic                       dueHeld,
  output logic [NUM_ELEM-1:0]        faultFlip,
  output logic [NUM_ELEM-1:0]        faultForce,
  output logic [NUM_ELEM-1:0]        faultForceVal
);

  localparam int CODES_W = CODE_W * NUM_ELEM;
  localparam logic [OFFSET_W-1:0] CNT_MAX = {OFFSET_W{1'b1}};

  logic [OFFSET_W-1:0] elapsed;
  logic [OFFSET_W-1:0] offHeld;
  logic [CODES_W-1:0]  codesHeld;
  logic                anyFire;

  // Enabled edges since the reference edge; saturates so late packages still fire.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      elapsed <= '0;
    end else if (strb.clearCnt) begin
      elapsed <= '0;
    end else if (duClkEn && (elapsed != CNT_MAX)) begin
      elapsed <= elapsed + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offHeld   <= '0;
      codesHeld <= '0;
    end else if (strb.loadPkg) begin
      offHeld   <= pkgOffset;
      codesHeld <= pkgCodes;
    end
  end

  assign dueIn   = (elapsed >= pkgOffset);
  assign dueHeld = (elapsed >= offHeld);
  assign anyFire = strb.fireIn || strb.fireHeld;

  for (genvar e = 0; e < NUM_ELEM; e++) begin : g_elem
    faultCode_t selCode;
    assign selCode = faultCode_t'(strb.fireIn ? pkgCodes[CODE_W*e +: CODE_W]
                                              : codesHeld[CODE_W*e +: CODE_W]);
    always_ff @(posedge clk) begin
      if (!rstN) begin
        faultFlip[e]     <= 1'b0;
        faultForce[e]    <= 1'b0;
        faultForceVal[e] <= 1'b0;
      end else begin
        faultFlip[e]     <= anyFire && (selCode == FC_FLIP);
        faultForce[e]    <= anyFire && ((selCode == FC_LOW) || (selCode == FC_HIGH));
        faultForceVal[e] <= anyFire && (selCode == FC_HIGH);
      end
    end
  end

  // R4: fault lines only follow an enabled edge
  assert_fault_gated_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((|faultFlip) || (|faultForce)) |-> $past(duClkEn));

  // R4: disabled edges leave the count untouched
  assert_count_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(duClkEn) && !$past(strb.clearCnt)) |-> $stable(elapsed));

endmodule

// File: rtl/fault_sched_seq.sv
module fault_sched_seq
  import fss_pkg::*;
#(
  parameter int NUM_ELEM = 16,
  parameter int OFFSET_W = 24
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       startPulse,
  input  logic                       duClkEn,
  input  logic                       pkgValid,
  output logic                       pkgReady,
  input  logic                       pkgLast,
  input  logic [OFFSET_W-1:0]        pkgOffset,
  input  logic [2*NUM_ELEM-1:0]      pkgCodes,
  output logic [NUM_ELEM-1:0]        faultFlip,
  output logic [NUM_ELEM-1:0]        faultForce,
  output logic [NUM_ELEM-1:0]        faultForceVal,
  output logic                       running,
  output logic                       done
);

  ctrlStrobe_t strb;
  logic        dueIn;
  logic        dueHeld;

  fss_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .duClkEn    (duClkEn),
    .pkgValid   (pkgValid),
    .pkgLast    (pkgLast),
    .dueIn      (dueIn),
    .dueHeld    (dueHeld),
    .pkgReady   (pkgReady),
    .running    (running),
    .done       (done),
    .strb       (strb)
  );

  fss_datapath #(
    .NUM_ELEM (NUM_ELEM),
    .OFFSET_W (OFFSET_W)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .duClkEn       (duClkEn),
    .strb          (strb),
    .pkgOffset     (pkgOffset),
    .pkgCodes      (pkgCodes),
    .dueIn         (dueIn),
    .dueHeld       (dueHeld),
    .faultFlip     (faultFlip),
    .faultForce    (faultForce),
    .faultForceVal (faultForceVal)
  );

endmodule

// File: tb/fault_sched_seq_bench.sv
module fault_sched_seq_bench;

  localparam int NE = 5;
  localparam int OW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startPulse = 1'b0, duClkEn = 1'b0, pkgValid = 1'b0, pkgLast = 1'b0;
  logic [OW-1:0]   pkgOffset = '0;
  logic [2*NE-1:0] pkgCodes = '0;
  logic pkgReady, running, done;
  logic [NE-1:0] faultFlip, faultForce, faultForceVal;

  always #10 clk = ~clk;

  fault_sched_seq #(.NUM_ELEM(NE), .OFFSET_W(OW)) u_fault_sched_seq (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .duClkEn(duClkEn),
    .pkgValid(pkgValid), .pkgReady(pkgReady), .pkgLast(pkgLast),
    .pkgOffset(pkgOffset), .pkgCodes(pkgCodes), .faultFlip(faultFlip),
    .faultForce(faultForce), .faultForceVal(faultForceVal),
    .running(running), .done(done));

  int errors = 0, checks = 0;
  string curTag = "R3";

  int qOff [0:63];
  logic [2*NE-1:0] qCode [0:63];
  int qGap [0:63];
  int qLen = 0, qIdx = 0, gap = 0;
  int enProb = 100;
  bit startReq = 0, prevStart = 0;

  // bench model: 0 idle, 1 fetch, 2 hold, 3 done
  int mState = 0, mElapsed = 0, mOff = 0;
  logic [2*NE-1:0] mCodes = '0;
  bit mLast = 0;
  logic [NE-1:0] expFlip = '0, expForce = '0, expVal = '0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic void setExp(input logic [2*NE-1:0] c);
    for (int i = 0; i < NE; i++) begin
      expFlip[i]  = (c[2*i +: 2] == 2'd1);
      expForce[i] = c[2*i+1];
      expVal[i]   = (c[2*i +: 2] == 2'd3);
    end
  endfunction

  task automatic cyc();
    bit fire, clr, acc;
    @(negedge clk);
    chk(faultFlip == expFlip, curTag, "flip R5", faultFlip, expFlip);
    chk(faultForce == expForce && faultForceVal == expVal, curTag, "force R5",
        {faultForce, faultForceVal}, {expForce, expVal});
    chk(pkgReady == (mState == 1), prevStart ? "R2" : "R6", "ready", pkgReady, mState == 1);
    chk(running == (mState == 1 || mState == 2), prevStart ? "R2" : "R8", "running",
        running, mState == 1 || mState == 2);
    chk(done == (mState == 3), "R8", "done", done, mState == 3);
    // drive
    duClkEn = ($urandom_range(99) < enProb);
    if (gap > 0) gap--;
    pkgValid  = (qIdx < qLen) && (gap == 0);
    pkgOffset = OW'(qOff[qIdx & 63]);
    pkgCodes  = qCode[qIdx & 63];
    pkgLast   = (qIdx == qLen - 1);
    startPulse = startReq;
    prevStart = startReq && (mState == 0 || mState == 3);
    startReq = 0;
    // predict the coming edge
    fire = 0; clr = 0; acc = 0;
    expFlip = '0; expForce = '0; expVal = '0;
    case (mState)
      0, 3: if (startPulse) begin mState = 1; clr = 1; end
      1: if (pkgValid) begin
           acc = 1;
           if (duClkEn && mElapsed >= qOff[qIdx]) begin
             fire = 1; clr = 1; setExp(pkgCodes);
             mState = pkgLast ? 3 : 1;
           end else begin
             mOff = qOff[qIdx]; mCodes = pkgCodes; mLast = pkgLast; mState = 2;
           end
         end
      2: if (duClkEn && mElapsed >= mOff) begin
           fire = 1; clr = 1; setExp(mCodes);
           mState = mLast ? 3 : 1;
         end
      default: ;
    endcase
    mElapsed = clr ? 0 : (duClkEn ? mElapsed + 1 : mElapsed);
    if (acc) begin
      qIdx++;
      gap = (qIdx < qLen) ? qGap[qIdx] : 0;
    end
    @(posedge clk);
  endtask

  task automatic runExp(input int n, input int extra);
    qLen = n; qIdx = 0; gap = qGap[0]; startReq = 1;
    for (int k = 0; k < 3000; k++) begin
      cyc();
      if (mState == 3 && qIdx == qLen) break;
    end
    for (int k = 0; k < extra; k++) cyc();
  endtask

  task automatic randFill(input int n, input int maxOff, input int maxGap);
    for (int i = 0; i < n; i++) begin
      qOff[i]  = $urandom_range(maxOff);
      qCode[i] = (2*NE)'($urandom);
      qGap[i]  = $urandom_range(maxGap);
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(faultFlip == 0 && faultForce == 0 && faultForceVal == 0, "R1", "faults in reset",
        {faultFlip, faultForce}, 0);
    chk(!pkgReady && !running && !done, "R1", "status in reset", {pkgReady, running, done}, 0);
    rstN = 1'b1;
    curTag = "R1";
    for (int k = 0; k < 4; k++) cyc();

    // R3: directed delays with full enable
    curTag = "R3";
    qOff[0] = 2; qCode[0] = 10'b00_01_10_11_01; qGap[0] = 0;
    qOff[1] = 5; qCode[1] = 10'b11_00_00_01_10; qGap[1] = 0;
    qOff[2] = 1; qCode[2] = 10'b10_11_01_00_00; qGap[2] = 0;
    runExp(3, 4);

    // R5: each code on each element in turn
    curTag = "R5";
    for (int i = 0; i < 4; i++) begin
      qOff[i] = 1; qGap[i] = 0;
      for (int e = 0; e < NE; e++) qCode[i][2*e +: 2] = 2'((i + e) % 4);
    end
    runExp(4, 2);

    // R7: zero delay, back-to-back firing
    curTag = "R7";
    for (int i = 0; i < 5; i++) begin
      qOff[i] = 0; qGap[i] = 0; qCode[i] = (2*NE)'($urandom);
    end
    runExp(5, 2);

    // R4: gated enable
    curTag = "R4";
    enProb = 40;
    randFill(8, 6, 0);
    runExp(8, 3);
    enProb = 100;

    // R9: late package past counter saturation, then a normal one
    curTag = "R9";
    qOff[0] = 3;  qCode[0] = 10'b01_01_01_01_01; qGap[0] = 22;
    qOff[1] = 15; qCode[1] = 10'b11_11_11_11_11; qGap[1] = 20;
    qOff[2] = 2;  qCode[2] = 10'b10_00_10_00_10; qGap[2] = 0;
    runExp(3, 2);

    // R8: start pulse while running is ignored, done holds
    curTag = "R8";
    qOff[0] = 6; qCode[0] = 10'b00_00_00_11_00; qGap[0] = 0;
    qOff[1] = 4; qCode[1] = 10'b01_00_00_00_00; qGap[1] = 0;
    qLen = 2; qIdx = 0; gap = 0; startReq = 1;
    cyc(); cyc(); cyc();
    startReq = 1;
    for (int k = 0; k < 30; k++) cyc();
    chk(done == 1'b1, "R8", "done after ignored start", done, 1);

    // R10: random schedules
    curTag = "R10";
    for (int x = 0; x < 8; x++) begin
      int n = $urandom_range(8, 1);
      enProb = $urandom_range(100, 30);
      randFill(n, 15, 3);
      runExp(n, 3);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule